// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block configures a downstream programmable device over a passive serial link. It first holds the target in reset by driving its active-low configuration-reset pin low. It then waits until the target reports that both of its status lines are low, lets fixed delays elapse on either side of releasing reset, and waits for the target's ready-status line to come back high. It then pulls bitstream bytes from a byte source and shifts each one out, most significant bit first, on a single data pin, with one configuration clock pulse per bit. After every complete byte it looks at the target's configuration-done line. Streaming ends when that line is high or when a byte budget is used up.

On a successful end the block sends a fixed number of extra clock pulses so the target can finish initialising, and then reports done. If the byte budget runs out, or a wait for a status pin lasts longer than its timeout, it reports an error. Both status inputs are asynchronous and go through a two-flop synchroniser, so the block sees them two clocks late. The configuration clock runs at the system clock divided by a parameter. The delays are set by a parameter giving system clocks per microsecond.

The byte source uses a valid/ready handshake. A byte transfers on a clock edge where `src_valid` and `src_ready` are both high. `src_ready` is high only while the serialiser is empty and the loader still needs data. The loader never takes a byte early. If the source holds `src_valid` low, the loader simply waits with the configuration clock low. The source must hold `src_data` stable while `src_valid` is high.

Top module: `ps_config_loader`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `error` and `src_ready` are 0, `tgt_reset_n` is 1, and `tgt_clk` and `tgt_data` are 0.
- R2: `cfg_start` is taken only while idle, done or error. Taking it restarts the whole sequence: the next cycle has `busy`=1, `done`=0, `error`=0 and `tgt_reset_n`=0. `cfg_start` while busy has no effect on any output. At most one of `busy`, `done` and `error` is 1 at a time.
- R3: `tgt_reset_n` stays 0 until the synchronised `tgt_status_n` and `tgt_done` both read 0. The synchroniser adds two clocks of lag. After that, `tgt_reset_n` stays 0 for a further DELAY_US*CLK_PER_US clocks and then goes to 1.
- R4: After `tgt_reset_n` rises, the block waits DELAY_US*CLK_PER_US clocks and then until the synchronised `tgt_status_n` reads 1. No byte is accepted (`src_ready`=0) before then.
- R5: Each accepted byte is sent MSB first on `tgt_data`. For each bit, `tgt_data` holds the bit for DCLK_DIV clocks with `tgt_clk` low and then for DCLK_DIV clocks with `tgt_clk` high. Between bytes, `src_ready` is 1 with `tgt_clk` low, and the block waits there for as long as `src_valid` is 0.
- R6: When a byte ends and the synchronised `tgt_done` reads 1, no further byte is accepted.
- R7: After R6, exactly INIT_CLKS more `tgt_clk` pulses are sent with `tgt_data` at 0, and then `done` goes to 1.
- R8: If BYTE_LIMIT bytes have been sent and `tgt_done` still reads 0 at the end of the last byte, `error` goes to 1 and no initialisation pulses are sent.
- R9: If the wait for both status pins low (R3), or the wait for `tgt_status_n` high (R4), lasts WAIT_LIMIT clocks, `error` goes to 1 without any byte being accepted.
- R10: `done` and `error` hold until the next accepted `cfg_start`. While either is 1, `tgt_reset_n` is 1 and `tgt_clk` and `tgt_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Request to begin (or restart) a configuration |
| src_valid | input | 1 | Byte source has a byte on `src_data` |
| src_data | input | DATA_W | Bitstream byte |
| src_ready | output | 1 | Loader accepts the byte this cycle |
| tgt_status_n | input | 1 | Target status line (asynchronous) |
| tgt_done | input | 1 | Target configuration-done line (asynchronous) |
| tgt_reset_n | output | 1 | Active-low configuration reset to the target |
| tgt_clk | output | 1 | Configuration clock; the target latches on its rising edge |
| tgt_data | output | 1 | Serial configuration data |
| busy | output | 1 | A configuration sequence is in progress |
| done | output | 1 | Last sequence completed successfully |
| error | output | 1 | Last sequence failed (byte budget or status timeout) |

## Verification
The bench emulates a target that drops both status lines a few clocks after reset goes low, releases its ready line later, and raises done once it has latched a chosen number of bytes. A design that sampled the status pins without the two-clock lag, or that cut the delay short, would release reset early and fail the reset-low duration check. A design that checked the done line in the middle of a byte, or one byte too late, would take too many or too few bytes, and a miscounted initialisation burst would show up in the total count of clock rising edges. Other runs cover stalled sources, a restart requested mid-stream, the byte budget running out, a target that never lowers its status lines, and a target that never becomes ready, each of which must end in the flag the requirements name and not hang.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [3:0] {
    LD_IDLE,
    LD_HOLD,
    LD_SETTLE,
    LD_RELEASE,
    LD_AWAIT,
    LD_STREAM,
    LD_FLUSH,
    LD_DONE,
    LD_FAIL
  } ld_state_t;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int   W       = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ps_bit_clock.sv
module ps_bit_clock #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk,
  output logic beat_end
);
  localparam int PH_W = (2 * DIV > 1) ? $clog2(2 * DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(DIV);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assign dclk     = run && (phase >= PH_HIGH);
  assign beat_end = run && (phase == PH_LAST);

  // R5: a phase that is stopped always restarts with the clock low
  p_stop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !dclk);
endmodule

// File: rtl/ps_serializer.sv
module ps_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              step,
  output logic              bit_o,
  output logic              full_o
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bits;
  logic              full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bits <= '0;
      full <= 1'b0;
    end else if (load) begin
      sh   <= din;
      bits <= '0;
      full <= 1'b1;
    end else if (step) begin
      if (bits == BIT_LAST) begin
        full <= 1'b0;
      end else begin
        sh   <= {sh[DATA_W-2:0], 1'b0};
        bits <= bits + BW'(1);
      end
    end
  end

  assign bit_o  = sh[DATA_W-1];
  assign full_o = full;

  // R5: a byte is only accepted into an empty shifter
  p_load_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);
  // R5: bits advance only while a byte is held
  p_step_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> full);
endmodule

// File: rtl/ps_config_loader.sv
module ps_config_loader
  import ps_cfg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CLK_PER_US = 100,
  parameter int DELAY_US   = 10,
  parameter int DCLK_DIV   = 4,
  parameter int BYTE_LIMIT = 1048576,
  parameter int INIT_CLKS  = 4000,
  parameter int WAIT_LIMIT = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              tgt_status_n,
  input  logic              tgt_done,
  output logic              tgt_reset_n,
  output logic              tgt_clk,
  output logic              tgt_data,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int DLY_CYC = DELAY_US * CLK_PER_US;
  localparam int TMAX    = (DLY_CYC > WAIT_LIMIT) ? DLY_CYC : WAIT_LIMIT;
  localparam int TMR_W   = $clog2(TMAX + 1);
  localparam int BCNT_W  = $clog2(BYTE_LIMIT + 1);
  localparam int ICNT_W  = $clog2(INIT_CLKS + 1);
  localparam logic [TMR_W-1:0]  DLY_LAST  = TMR_W'(DLY_CYC - 1);
  localparam logic [TMR_W-1:0]  WAIT_LAST = TMR_W'(WAIT_LIMIT - 1);
  localparam logic [BCNT_W-1:0] BYTE_MAX  = BCNT_W'(BYTE_LIMIT);
  localparam logic [ICNT_W-1:0] INIT_LAST = ICNT_W'(INIT_CLKS - 1);

  ld_state_t         state, state_nxt;
  logic [TMR_W-1:0]  tmr, tmr_nxt;
  logic [BCNT_W-1:0] bytes, bytes_nxt;
  logic [ICNT_W-1:0] icnt, icnt_nxt;
  logic [1:0]        pins_s;
  logic              st_s, cd_s;
  logic              rdy, take;
  logic              run, beat_end, dclk;
  logic              ser_bit, ser_full, ser_step;

  ps_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({tgt_status_n, tgt_done}),
    .q     (pins_s)
  );
  assign st_s = pins_s[1];
  assign cd_s = pins_s[0];

  assign run      = ((state == LD_STREAM) && ser_full) || (state == LD_FLUSH);
  assign ser_step = beat_end && (state == LD_STREAM);
  assign take     = rdy && src_valid;

  ps_bit_clock #(.DIV(DCLK_DIV)) u_bclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .dclk     (dclk),
    .beat_end (beat_end)
  );

  ps_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take),
    .din    (src_data),
    .step   (ser_step),
    .bit_o  (ser_bit),
    .full_o (ser_full)
  );

  always_comb begin
    state_nxt = state;
    tmr_nxt   = tmr;
    bytes_nxt = bytes;
    icnt_nxt  = icnt;
    rdy       = 1'b0;
    unique case (state)
      LD_IDLE, LD_DONE, LD_FAIL: begin
        if (cfg_start) begin
          state_nxt = LD_HOLD;
          tmr_nxt   = '0;
          bytes_nxt = '0;
          icnt_nxt  = '0;
        end
      end
      LD_HOLD: begin
        if (!st_s && !cd_s) begin
          state_nxt = LD_SETTLE;
          tmr_nxt   = '0;
        end else if (tmr == WAIT_LAST) begin
          state_nxt = LD_FAIL;
        end else begin
          tmr_nxt = tmr + TMR_W'(1);
        end
      end
      LD_SETTLE: begin
        if (tmr == DLY_LAST) begin
          state_nxt = LD_RELEASE;
          tmr_nxt   = '0;
        end else begin
          tmr_nxt = tmr + TMR_W'(1);
        end
      end
      LD_RELEASE: begin
        if (tmr == DLY_LAST) begin
          state_nxt = LD_AWAIT;
          tmr_nxt   = '0;
        end else begin
          tmr_nxt = tmr + TMR_W'(1);
        end
      end
      LD_AWAIT: begin
        if (st_s) begin
          state_nxt = LD_STREAM;
        end else if (tmr == WAIT_LAST) begin
          state_nxt = LD_FAIL;
        end else begin
          tmr_nxt = tmr + TMR_W'(1);
        end
      end
      LD_STREAM: begin
        if (!ser_full) begin
          if (cd_s) begin
            state_nxt = LD_FLUSH;
          end else if (bytes == BYTE_MAX) begin
            state_nxt = LD_FAIL;
          end else begin
            rdy = 1'b1;
            if (src_valid) begin
              bytes_nxt = bytes + BCNT_W'(1);
            end
          end
        end
      end
      LD_FLUSH: begin
        if (beat_end) begin
          if (icnt == INIT_LAST) begin
            state_nxt = LD_DONE;
          end else begin
            icnt_nxt = icnt + ICNT_W'(1);
          end
        end
      end
      default: state_nxt = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LD_IDLE;
      tmr   <= '0;
      bytes <= '0;
      icnt  <= '0;
    end else begin
      state <= state_nxt;
      tmr   <= tmr_nxt;
      bytes <= bytes_nxt;
      icnt  <= icnt_nxt;
    end
  end

  assign src_ready   = rdy;
  assign tgt_reset_n = !((state == LD_HOLD) || (state == LD_SETTLE));
  assign tgt_clk     = dclk;
  assign tgt_data    = ser_full && ser_bit;
  assign busy        = !((state == LD_IDLE) || (state == LD_DONE) || (state == LD_FAIL));
  assign done        = (state == LD_DONE);
  assign error       = (state == LD_FAIL);

  // R2: the three status flags are mutually exclusive
  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, error}));
  // R4: no byte is requested while the target is held in reset
  p_no_ready_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (tgt_reset_n && !tgt_clk));
  // R5: data is settled before the rising clock edge and held while high
  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_clk) |-> $stable(tgt_data));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk && $past(tgt_clk)) |-> $stable(tgt_data));
  // R6: once the finishing burst starts no byte is accepted
  p_flush_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LD_FLUSH) |-> !src_ready);
  // R7: the burst counter stays inside its window
  p_init_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    icnt <= INIT_LAST);
  // R8: never more bytes than the budget
  p_byte_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bytes <= BYTE_MAX);
  // R10: quiet pins while a result is shown
  p_result_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (tgt_reset_n && !tgt_clk && !tgt_data));
endmodule

// File: tb/ps_config_loader_bench.sv
module ps_config_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU   = 3;
  localparam int DUS   = 10;
  localparam int DLY   = CPU * DUS;
  localparam int DIV   = 2;
  localparam int LIM   = 12;
  localparam int INIT  = 4000;
  localparam int WAITL = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 1'b0;
  logic src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic src_ready;
  logic tgt_status_n = 1'b1;
  logic tgt_done = 1'b1;
  logic tgt_reset_n, tgt_clk, tgt_data, busy, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_config_loader #(
    .DATA_W(8), .CLK_PER_US(CPU), .DELAY_US(DUS), .DCLK_DIV(DIV),
    .BYTE_LIMIT(LIM), .INIT_CLKS(INIT), .WAIT_LIMIT(WAITL)
  ) u_ps_config_loader (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .tgt_status_n(tgt_status_n), .tgt_done(tgt_done),
    .tgt_reset_n(tgt_reset_n), .tgt_clk(tgt_clk), .tgt_data(tgt_data),
    .busy(busy), .done(done), .error(error)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- cycle reference model ----------------
  int m_st, m_tmr, m_bytes, m_icnt, m_bit, m_ph;
  bit m_have, h1s, h2s, h1c, h2c;
  logic [7:0] m_sh;
  bit e_ncfg, e_dclk, e_d0, e_rdy, e_busy, e_done, e_err;

  always @(posedge clk or negedge rst_n) begin
    bit run, beat, rdy, take, have0;
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_bytes = 0; m_icnt = 0; m_bit = 0; m_ph = 0;
      m_have = 0; m_sh = 8'h00;
      h1s = 1; h2s = 1; h1c = 1; h2c = 1;
    end else begin
      run   = ((m_st == 5) && m_have) || (m_st == 6);
      beat  = run && (m_ph == 2*DIV-1);
      rdy   = (m_st == 5) && !m_have && !h2c && (m_bytes != LIM);
      take  = rdy && src_valid;
      have0 = m_have;
      m_ph  = run ? (beat ? 0 : m_ph + 1) : 0;
      if (take) begin
        m_sh = src_data; m_bit = 0; m_have = 1;
      end else if (beat && m_st == 5) begin
        if (m_bit == 7) m_have = 0;
        else begin m_sh = {m_sh[6:0], 1'b0}; m_bit++; end
      end
      case (m_st)
        0, 7, 8: if (cfg_start) begin m_st = 1; m_tmr = 0; m_bytes = 0; m_icnt = 0; end
        1: if (!h2s && !h2c) begin m_st = 2; m_tmr = 0; end
           else if (m_tmr == WAITL-1) m_st = 8;
           else m_tmr++;
        2: if (m_tmr == DLY-1) begin m_st = 3; m_tmr = 0; end else m_tmr++;
        3: if (m_tmr == DLY-1) begin m_st = 4; m_tmr = 0; end else m_tmr++;
        4: if (h2s) m_st = 5;
           else if (m_tmr == WAITL-1) m_st = 8;
           else m_tmr++;
        5: if (!have0) begin
             if (h2c) m_st = 6;
             else if (m_bytes == LIM) m_st = 8;
             else if (take) m_bytes++;
           end
        6: if (beat) begin
             if (m_icnt == INIT-1) m_st = 7; else m_icnt++;
           end
        default: m_st = 0;
      endcase
      h2s = h1s; h1s = tgt_status_n;
      h2c = h1c; h1c = tgt_done;
    end
    e_ncfg = !(m_st == 1 || m_st == 2);
    e_dclk = (((m_st == 5) && m_have) || (m_st == 6)) && (m_ph >= DIV);
    e_d0   = m_have ? m_sh[7] : 1'b0;
    e_rdy  = (m_st == 5) && !m_have && !h2c && (m_bytes != LIM);
    e_busy = !(m_st == 0 || m_st == 7 || m_st == 8);
    e_done = (m_st == 7);
    e_err  = (m_st == 8);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3", "tgt_reset_n", tgt_reset_n, e_ncfg);
      chk("R4", "src_ready", src_ready, e_rdy);
      chk("R5", "tgt_clk", tgt_clk, e_dclk);
      chk("R5", "tgt_data", tgt_data, e_d0);
      chk("R2", "busy", busy, e_busy);
      chk("R7", "done", done, e_done);
      chk("R8", "error", error, e_err);
    end
  end

  // ---------------- byte source ----------------
  logic [7:0] src_q[$];
  int taken = 0;
  bit gap_mode = 0;
  bit pend = 0;
  int cyc = 0;

  initial forever begin
    @(negedge clk);
    cyc++;
    #2;
    if (pend && src_q.size() > 0) begin
      void'(src_q.pop_front());
      taken++;
      src_valid = 1'b0;
    end
    if (src_q.size() == 0) src_valid = 1'b0;
    else if (!src_valid && !(gap_mode && (cyc % 3 == 0))) begin
      src_valid = 1'b1;
      src_data  = src_q[0];
    end
    #1;
    pend = src_valid && src_ready;
  end

  // ---------------- target emulation ----------------
  int t_cfg = 4;
  bit t_stick = 0, t_norel = 0;
  int rises = 0, bits_in = 0, lo_n = 0, hi_n = 0, low_cnt = 0;
  bit armed = 0, low_track = 0, prev_dclk = 0;
  logic [7:0] cap_sh = 8'h00;
  logic [7:0] cap_q[$];

  initial forever begin
    bit c_ncfg, c_dclk, c_d0;
    @(negedge clk);
    c_ncfg = tgt_reset_n; c_dclk = tgt_clk; c_d0 = tgt_data;
    if (c_dclk && !prev_dclk) begin
      rises++;
      if (tgt_status_n && !tgt_done) begin
        cap_sh = {cap_sh[6:0], c_d0};
        bits_in++;
        if (bits_in % 8 == 0) cap_q.push_back(cap_sh);
      end
    end
    prev_dclk = c_dclk;
    if (low_track) begin
      if (!c_ncfg) low_cnt++; else low_track = 0;
    end
    #2;
    if (!c_ncfg) begin
      hi_n = 0; lo_n++;
      if (lo_n == 4 && !t_stick) begin
        tgt_status_n = 1'b0; tgt_done = 1'b0; bits_in = 0;
        armed = 1; low_track = 1; low_cnt = 0;
      end
    end else begin
      lo_n = 0;
      if (armed) begin
        hi_n++;
        if (hi_n == 5 && !t_norel) begin tgt_status_n = 1'b1; armed = 0; end
      end
      if (tgt_status_n && !tgt_done && bits_in >= 8*t_cfg) tgt_done = 1'b1;
    end
  end

  // ---------------- scenario helpers ----------------
  task automatic setup(input int cfg, input bit gap, input bit stick, input bit norel,
                       input int nbytes, input int seed);
    @(negedge clk); #5;
    src_q.delete();
    for (int i = 0; i < nbytes; i++) src_q.push_back(8'((seed + i * 53) ^ (i * 7)));
    taken = 0; rises = 0; cap_q.delete();
    t_cfg = cfg; gap_mode = gap; t_stick = stick; t_norel = norel;
  endtask

  task automatic pulse_start();
    @(negedge clk); #2 cfg_start = 1'b1;
    @(negedge clk); #2 cfg_start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic clear_src();
    @(negedge clk); #5 src_q.delete();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] ref_q[$];
    int nc;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset error", error, 0);
    chk("R1", "reset tgt_reset_n", tgt_reset_n, 1);
    chk("R1", "reset tgt_clk", tgt_clk, 0);
    chk("R1", "reset tgt_data", tgt_data, 0);
    chk("R1", "reset src_ready", src_ready, 0);

    // S1: success with a stalling source and a start request while busy
    setup(6, 1, 0, 0, 10, 8'hA5);
    ref_q = src_q;
    pulse_start();
    @(negedge clk);
    chk("R2", "busy after start", busy, 1);
    chk("R2", "reset low after start", tgt_reset_n, 0);
    nc = 0;
    while (taken < 2 && nc < 5000) begin @(negedge clk); nc++; end
    pulse_start();
    @(negedge clk);
    chk("R2", "start while busy ignored", busy, 1);
    wait_end();
    chk("R7", "S1 done", done, 1);
    chk("R7", "S1 error", error, 0);
    chk("R3", "reset low cycles after pins low", low_cnt, DLY + 2);
    chk("R6", "S1 bytes taken", taken, 6);
    chk("R7", "S1 clock pulses", rises, 6*8 + INIT);
    chk("R5", "S1 bytes captured", cap_q.size(), 6);
    for (int i = 0; i < 6 && i < cap_q.size(); i++)
      chk("R5", "S1 byte value", cap_q[i], ref_q[i]);
    rises = 0;
    repeat (20) @(negedge clk);
    chk("R10", "done held", done, 1);
    chk("R10", "no pulses while done", rises, 0);
    chk("R6", "no byte taken after done", taken, 6);
    clear_src();

    // S2: restart from done, no stalls, edge bit patterns
    setup(3, 0, 0, 0, 3, 8'h00);
    src_q[0] = 8'h01; src_q[1] = 8'h80; src_q[2] = 8'h55;
    src_q.push_back(8'hFF);
    ref_q = src_q;
    pulse_start();
    @(negedge clk);
    chk("R2", "done cleared on restart", done, 0);
    chk("R2", "busy on restart", busy, 1);
    wait_end();
    chk("R7", "S2 done", done, 1);
    chk("R6", "S2 bytes taken", taken, 3);
    chk("R7", "S2 clock pulses", rises, 3*8 + INIT);
    for (int i = 0; i < 3 && i < cap_q.size(); i++)
      chk("R5", "S2 byte value", cap_q[i], ref_q[i]);
    clear_src();

    // S3: byte budget exhausted
    setup(100, 1, 0, 0, 20, 8'h3C);
    pulse_start();
    wait_end();
    chk("R8", "S3 error", error, 1);
    chk("R8", "S3 done", done, 0);
    chk("R8", "S3 bytes taken", taken, LIM);
    chk("R8", "S3 no init pulses", rises, LIM*8);
    repeat (10) @(negedge clk);
    chk("R10", "error held", error, 1);
    clear_src();

    // S4: target never drops its status lines (restart from error)
    setup(2, 0, 1, 0, 4, 8'h11);
    pulse_start();
    @(negedge clk);
    chk("R2", "error cleared on restart", error, 0);
    wait_end();
    chk("R9", "S4 error", error, 1);
    chk("R9", "S4 bytes taken", taken, 0);
    chk("R10", "S4 reset released", tgt_reset_n, 1);
    clear_src();
    t_stick = 0;
    repeat (8) @(negedge clk);

    // S5: target never reports ready
    setup(2, 0, 0, 1, 4, 8'h22);
    pulse_start();
    wait_end();
    chk("R9", "S5 error", error, 1);
    chk("R4", "S5 no bytes before ready", taken, 0);
    chk("R9", "S5 no pulses", rises, 0);
    clear_src();

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule